// File: doc/BRIEF.md
# Supervisor Trap Entry and Return Sequencer

This block runs the control sequence that moves a small stack-based processor from user mode into supervisor mode when a trap is taken, and back again when the handler returns. Three kinds of event can start a trap: a hardware interrupt request, a software trap instruction, and a privileged opcode issued from user mode. On entry the sequencer swaps the core onto its own supervisor stack. It writes a three-word context frame there through a single-beat memory port: the interrupted user stack pointer, the condition codes and the resume PC. It then hands the core a handler address taken from a fixed vector base and raises supervisor mode.

A return-from-exception operation issued in supervisor mode runs the frame in reverse. It reads the three words back and gives the core the saved PC, condition codes and user stack pointer to load. It also records the new top of the supervisor stack and drops back to user mode. While either sequence runs, a busy flag stalls the fetch stage. The core owns instruction decode and the live stack pointer. The sequencer only tells it when to load a new value and what that value is.

Top module: `trap_seq`

## Requirements
- R1: After synchronous reset the block is in user mode with busy, done, all load strobes and mem_req low, and the stored supervisor stack pointer equals the parameter SSP_RESET.
- R2: In user mode an entry starts when an event is present in an idle cycle. Cause index 0 is a privileged violation (priv_op or rfe_req), index 1 is a software trap and index 2 is a hardware interrupt. When events coincide, the lowest index wins.
- R3: The entry issues three write beats below the stored supervisor pointer S, in this order: the user stack pointer (sp_in) to S-4, then the condition codes zero-extended to 32 bits to S-8, then the saved PC to S-12. All entry writes happen while the block is still in user mode.
- R4: Each memory beat holds mem_req, mem_we, mem_addr and mem_wdata unchanged until a cycle with mem_ack high. Exactly one beat completes per acknowledged cycle.
- R5: The saved PC is next_pc for a software trap. It is cur_pc for a privileged violation or a hardware interrupt.
- R6: The cycle after the third entry acknowledge has done, pc_load and sp_load high, with pc_value equal to VEC_BASE + 4 × cause and sp_value equal to S-12. From the next cycle on, sup_mode is 1 and busy is 0.
- R7: In supervisor mode, hw_irq, sw_trap and priv_op start nothing: busy and mem_req stay low.
- R8: rfe_req in supervisor mode reads three words starting at T = sp_in: the PC at T, the condition codes at T+4 and the user stack pointer at T+8. In the cycle after the third acknowledge, done, pc_load, ccr_load and sp_load present the PC, the low CCR bits and the user stack pointer. sup_mode is 0 from the next cycle, and the stored supervisor pointer becomes T+12.
- R9: rfe_req issued in user mode is a privileged violation: cause 0, with cur_pc saved.
- R10: busy is high from the cycle after an event is accepted through the done cycle. Events present while busy are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | 1 | Hardware interrupt request |
| sw_trap | input | 1 | Software trap instruction in execute |
| priv_op | input | 1 | Privileged opcode in execute |
| rfe_req | input | 1 | Return-from-exception in execute |
| cur_pc | input | 32 | Address of the instruction in execute |
| next_pc | input | 32 | Address of the following instruction |
| cur_ccr | input | 8 | Current condition codes |
| sp_in | input | 32 | Core's live stack pointer |
| busy | output | 1 | Sequence in progress, stall fetch |
| done | output | 1 | One-cycle completion strobe |
| sup_mode | output | 1 | 1 = supervisor mode |
| pc_load | output | 1 | Load pc_value into the PC |
| pc_value | output | 32 | Handler address or restored PC |
| ccr_load | output | 1 | Load ccr_value into the CCR |
| ccr_value | output | 8 | Restored condition codes |
| sp_load | output | 1 | Load sp_value into the stack pointer |
| sp_value | output | 32 | New stack pointer |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted |

## Verification
An event seen at a clock edge in an idle cycle makes busy and the first beat request visible in the following cycle. Each beat advances on the edge where mem_ack is sampled high. The done cycle with its load strobes comes one edge after the third acknowledge, and the mode change appears one edge after that. The bench drives inputs and samples outputs on falling edges. It tracks each of these cycles explicitly and delays acknowledges by random amounts, so address and data are checked both when first presented and again just before they are acknowledged. Expected frames, vectors and supervisor pointers come from a bench model that carries the stored pointer across entry and return pairs.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN        = 32;
    localparam int CCR_W       = 8;
    localparam int FRAME_WORDS = 3;
    localparam int WORD_BYTES  = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        CAUSE_PRIV = 2'd0,
        CAUSE_SWT  = 2'd1,
        CAUSE_HWI  = 2'd2,
        CAUSE_NONE = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_ENT_FIN,
        ST_RET_FIN
    } seq_st_e;

    // frame slot indices in push order
    localparam int SLOT_USP = 0;
    localparam int SLOT_CCR = 1;
    localparam int SLOT_PC  = 2;

    function automatic word_t vector_of(word_t base, cause_e c);
        return base + (word_t'(c) << 2);
    endfunction
endpackage

// File: rtl/trap_pick.sv
module trap_pick
    import trap_pkg::*;
(
    input  logic   user_mode,
    input  logic   priv_op,
    input  logic   rfe_req,
    input  logic   sw_trap,
    input  logic   hw_irq,
    output logic   take,
    output cause_e cause
);
    // fixed priority: privilege fault, then software trap, then interrupt
    always_comb begin
        if (priv_op || rfe_req) cause = CAUSE_PRIV;
        else if (sw_trap)       cause = CAUSE_SWT;
        else if (hw_irq)        cause = CAUSE_HWI;
        else                    cause = CAUSE_NONE;
        take = user_mode && (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/trap_frame.sv
module trap_frame
    import trap_pkg::*;
#(
    parameter int WORDS = FRAME_WORDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_push,
    input  logic                start_pop,
    input  word_t               base_in,
    input  word_t [WORDS-1:0]   words_in,
    input  logic                beat_ack,
    input  word_t               rdata,
    output word_t               addr,
    output word_t               wdata,
    output logic                last_beat,
    output word_t               end_ptr,
    output word_t [WORDS-1:0]   words_out
);
    localparam int    BW   = $clog2(WORDS + 1);
    localparam word_t STEP = word_t'(WORD_BYTES);
    localparam word_t SPAN = word_t'(WORDS * WORD_BYTES);

    word_t             base_q;
    logic              pop_q;
    logic [BW-1:0]     beat_q;
    word_t [WORDS-1:0] ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            pop_q  <= 1'b0;
            beat_q <= '0;
        end else if (start_push || start_pop) begin
            base_q <= base_in;
            pop_q  <= start_pop;
            beat_q <= '0;
        end else if (beat_ack) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // one context register per frame slot; pops fill in reverse slot order
    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ctx_q[k] <= '0;
            else if (start_push)
                ctx_q[k] <= words_in[k];
            else if (beat_ack && pop_q && beat_q == BW'(WORDS - 1 - k))
                ctx_q[k] <= rdata;
        end
    end

    always_comb begin
        wdata = '0;
        for (int k = 0; k < WORDS; k++)
            if (beat_q == BW'(k)) wdata = ctx_q[k];
    end

    assign addr      = pop_q ? base_q + word_t'(beat_q) * STEP
                             : base_q - (word_t'(beat_q) + 1) * STEP;
    assign last_beat = (beat_q == BW'(WORDS - 1));
    assign end_ptr   = pop_q ? base_q + SPAN : base_q - SPAN;
    assign words_out = ctx_q;

    assert_beat_range_R4: assert property (@(posedge clk) disable iff (rst)
        beat_ack |-> beat_q < BW'(WORDS));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter logic [31:0] VEC_BASE  = 32'h0000_0100,
    parameter logic [31:0] SSP_RESET = 32'h0000_8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hw_irq,
    input  logic        sw_trap,
    input  logic        priv_op,
    input  logic        rfe_req,
    input  logic [31:0] cur_pc,
    input  logic [31:0] next_pc,
    input  logic [7:0]  cur_ccr,
    input  logic [31:0] sp_in,
    output logic        busy,
    output logic        done,
    output logic        sup_mode,
    output logic        pc_load,
    output logic [31:0] pc_value,
    output logic        ccr_load,
    output logic [7:0]  ccr_value,
    output logic        sp_load,
    output logic [31:0] sp_value,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    seq_st_e st_q, st_d;
    logic    mode_q;
    word_t   ssp_q;
    cause_e  cause_q, pick_cause;
    logic    pick_take;

    logic    start_push, start_pop, beat_ack, last_beat;
    word_t   frame_addr, frame_wdata, frame_end, frame_base;
    word_t [FRAME_WORDS-1:0] frame_in, frame_out;

    trap_pick u_pick (
        .user_mode (!mode_q),
        .priv_op   (priv_op),
        .rfe_req   (rfe_req),
        .sw_trap   (sw_trap),
        .hw_irq    (hw_irq),
        .take      (pick_take),
        .cause     (pick_cause)
    );

    assign start_push = (st_q == ST_IDLE) && pick_take;
    assign start_pop  = (st_q == ST_IDLE) && mode_q && rfe_req;
    assign beat_ack   = mem_ack && (st_q == ST_PUSH || st_q == ST_POP);
    assign frame_base = start_pop ? sp_in : ssp_q;

    always_comb begin
        frame_in           = '0;
        frame_in[SLOT_USP] = sp_in;
        frame_in[SLOT_CCR] = word_t'(cur_ccr);
        frame_in[SLOT_PC]  = (pick_cause == CAUSE_SWT) ? next_pc : cur_pc;
    end

    trap_frame #(.WORDS(FRAME_WORDS)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .start_push (start_push),
        .start_pop  (start_pop),
        .base_in    (frame_base),
        .words_in   (frame_in),
        .beat_ack   (beat_ack),
        .rdata      (mem_rdata),
        .addr       (frame_addr),
        .wdata      (frame_wdata),
        .last_beat  (last_beat),
        .end_ptr    (frame_end),
        .words_out  (frame_out)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (start_push) st_d = ST_PUSH;
                        else if (start_pop) st_d = ST_POP;
            ST_PUSH:    if (mem_ack && last_beat) st_d = ST_ENT_FIN;
            ST_POP:     if (mem_ack && last_beat) st_d = ST_RET_FIN;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            mode_q  <= 1'b0;
            ssp_q   <= SSP_RESET;
            cause_q <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
            if (start_push) cause_q <= pick_cause;
            if (st_q == ST_ENT_FIN) mode_q <= 1'b1;
            if (st_q == ST_RET_FIN) begin
                mode_q <= 1'b0;
                ssp_q  <= frame_end;
            end
        end
    end

    always_comb begin
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_ENT_FIN) || (st_q == ST_RET_FIN);
        pc_load   = done;
        sp_load   = done;
        ccr_load  = (st_q == ST_RET_FIN);
        pc_value  = '0;
        sp_value  = '0;
        ccr_value = '0;
        if (st_q == ST_ENT_FIN) begin
            pc_value = vector_of(VEC_BASE, cause_q);
            sp_value = frame_end;
        end else if (st_q == ST_RET_FIN) begin
            pc_value  = frame_out[SLOT_PC];
            sp_value  = frame_out[SLOT_USP];
            ccr_value = frame_out[SLOT_CCR][CCR_W-1:0];
        end
        mem_req   = (st_q == ST_PUSH) || (st_q == ST_POP);
        mem_we    = (st_q == ST_PUSH);
        mem_addr  = mem_req ? frame_addr : '0;
        mem_wdata = mem_we ? frame_wdata : '0;
    end

    assign sup_mode = mode_q;

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    assert_write_user_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !sup_mode);
    assert_read_sup_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> sup_mode);
    assert_enter_mode_R6: assert property (@(posedge clk) disable iff (rst)
        done && !sup_mode |=> sup_mode && !busy);
    assert_leave_mode_R8: assert property (@(posedge clk) disable iff (rst)
        done && sup_mode |=> !sup_mode && !busy);
    assert_sup_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        sup_mode && !busy && !rfe_req |=> !busy);
    assert_load_done_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load || sp_load || ccr_load) |-> done && busy);
endmodule

// File: tb/test_trap_seq.sv
module test_trap_seq;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VEC        = 32'h0000_0100;
    localparam logic [31:0] SSP0       = 32'h0000_8000;

    logic clk = 1'b0, rst = 1'b1;
    logic hw_irq = 0, sw_trap = 0, priv_op = 0, rfe_req = 0;
    logic [31:0] cur_pc = 0, next_pc = 0, sp_in = 0, mem_rdata = 0;
    logic [7:0]  cur_ccr = 0;
    logic        mem_ack = 0;
    logic busy, done, sup_mode, pc_load, ccr_load, sp_load, mem_req, mem_we;
    logic [31:0] pc_value, sp_value, mem_addr, mem_wdata;
    logic [7:0]  ccr_value;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] exp_ssp = SSP0;

    trap_seq #(.VEC_BASE(VEC), .SSP_RESET(SSP0)) i_trap_seq (
        .clk(clk), .rst(rst), .hw_irq(hw_irq), .sw_trap(sw_trap), .priv_op(priv_op),
        .rfe_req(rfe_req), .cur_pc(cur_pc), .next_pc(next_pc), .cur_ccr(cur_ccr),
        .sp_in(sp_in), .busy(busy), .done(done), .sup_mode(sup_mode),
        .pc_load(pc_load), .pc_value(pc_value), .ccr_load(ccr_load), .ccr_value(ccr_value),
        .sp_load(sp_load), .sp_value(sp_value), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int cause_of(bit p, bit r, bit s, bit h);
        if (p || r) return 0;
        if (s)      return 1;
        if (h)      return 2;
        return 3;
    endfunction

    // serve one memory beat: wait for request, check it, hold a random time, acknowledge
    task automatic serve(input bit wr, input logic [31:0] ea, input logic [31:0] ew,
                         input logic [31:0] rd, input string tag);
        int n = 0;
        while (!mem_req && n < 20) begin @(negedge clk); n++; end
        chk(mem_req === 1'b1, {tag, " R4 request"}, 32'(mem_req), 32'd1);
        chk(mem_addr === ea, {tag, " address"}, mem_addr, ea);
        chk(mem_we === wr, {tag, " direction"}, 32'(mem_we), 32'(wr));
        if (wr) chk(mem_wdata === ew, {tag, " R3 data"}, mem_wdata, ew);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === ea && (!wr || mem_wdata === ew),
            {tag, " R4 hold"}, mem_addr, ea);
        mem_ack = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = $urandom;
    endtask

    task automatic enter(input bit p, input bit r, input bit s, input bit h,
                         input logic [31:0] pc, input logic [31:0] npc,
                         input logic [31:0] usp, input logic [7:0] ccr);
        int c = cause_of(p, r, s, h);
        logic [31:0] spc = (c == 1) ? npc : pc;   // R5
        logic [31:0] base = exp_ssp;
        priv_op = p; rfe_req = r; sw_trap = s; hw_irq = h;
        cur_pc = pc; next_pc = npc; sp_in = usp; cur_ccr = ccr;
        @(negedge clk);
        priv_op = 0; rfe_req = 0; sw_trap = 0; hw_irq = 0;
        chk(busy === 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
        serve(1'b1, base - 4,  usp,          0, "R3 usp");
        serve(1'b1, base - 8,  32'(ccr),     0, "R3 ccr");
        serve(1'b1, base - 12, spc,          0, "R5 saved pc");
        chk(done && pc_load && sp_load && busy && !ccr_load, "R6 strobes", {28'd0, done, pc_load, sp_load, ccr_load}, 32'he);
        chk(pc_value === VEC + 32'(c) * 4, "R2 R6 vector", pc_value, VEC + 32'(c) * 4);
        chk(sp_value === base - 12, "R6 sp", sp_value, base - 12);
        @(negedge clk);
        chk(sup_mode === 1'b1 && busy === 1'b0, "R6 mode", {30'd0, sup_mode, busy}, 32'h2);
    endtask

    task automatic leave(input logic [31:0] t, input logic [31:0] rpc, input logic [31:0] rusp,
                         input logic [31:0] rccrw, input bit poke);
        sp_in = t; rfe_req = 1'b1;
        @(negedge clk);
        rfe_req = 1'b0;
        if (poke) begin hw_irq = 1'b1; sw_trap = 1'b1; end   // R10: arrive while busy
        serve(1'b0, t,     0, rpc,   "R8 pop pc");
        hw_irq = 1'b0; sw_trap = 1'b0;
        serve(1'b0, t + 4, 0, rccrw, "R8 pop ccr");
        serve(1'b0, t + 8, 0, rusp,  "R8 pop usp");
        chk(done && pc_load && sp_load && ccr_load, "R8 strobes", {28'd0, done, pc_load, sp_load, ccr_load}, 32'hf);
        chk(pc_value === rpc, "R8 pc", pc_value, rpc);
        chk(ccr_value === rccrw[7:0], "R8 ccr", 32'(ccr_value), 32'(rccrw[7:0]));
        chk(sp_value === rusp, "R8 usp", sp_value, rusp);
        @(negedge clk);
        chk(sup_mode === 1'b0, "R8 user mode", 32'(sup_mode), 0);
        chk(busy === 1'b0, "R10 idle after return", 32'(busy), 0);
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0, "R10 no latched event", 32'(busy), 0);
        exp_ssp = t + 12;
    endtask

    task automatic sup_ignore();
        hw_irq = 1; sw_trap = 1; priv_op = 1;
        @(negedge clk);
        hw_irq = 0; sw_trap = 0; priv_op = 0;
        repeat (2) begin
            chk(busy === 1'b0 && mem_req === 1'b0, "R7 supervisor ignores", {30'd0, busy, mem_req}, 0);
            @(negedge clk);
        end
        chk(sup_mode === 1'b1, "R7 still supervisor", 32'(sup_mode), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !sup_mode && !mem_req && !pc_load && !sp_load && !ccr_load,
            "R1 reset state", {25'd0, busy, done, sup_mode, mem_req, pc_load, sp_load, ccr_load}, 0);

        // directed: all events together, first frame at SSP_RESET (R1, R2)
        enter(1, 0, 1, 1, 32'h0000_1000, 32'h0000_1004, 32'h0000_4000, 8'hA5);
        sup_ignore();
        leave(32'h0000_7FF4, 32'h0000_1000, 32'h0000_4000, 32'hFFFF_FFA5, 1'b1);
        // software beats interrupt, saved pc is next_pc (R2, R5)
        enter(0, 0, 1, 1, 32'h0000_2000, 32'h0000_2008, 32'h0000_3FF0, 8'h01);
        leave(32'h0000_7FF4, 32'h0000_2008, 32'h0000_3FF0, 32'h0000_0001, 1'b0);
        // interrupt alone (R2)
        enter(0, 0, 0, 1, 32'h0000_3000, 32'h0000_3004, 32'h0000_3F00, 8'h80);
        leave(32'h0000_7FF4, 32'h0000_3000, 32'h0000_3F00, 32'h0000_0080, 1'b0);
        // return instruction issued in user mode is a violation (R9)
        enter(0, 1, 0, 0, 32'h0000_4444, 32'h0000_4448, 32'h0000_3E00, 8'h3C);
        leave(32'h0000_6000, 32'h0000_4444, 32'h0000_3E00, 32'h0000_003C, 1'b0);

        for (int it = 0; it < 40; it++) begin
            logic [3:0] f = 4'($urandom_range(1, 15));
            logic [31:0] pc = $urandom & 32'hFFFF_FFFC;
            enter(f[0], f[1], f[2], f[3], pc, pc + 4, $urandom & 32'hFFFF_FFFC, 8'($urandom));
            if (it % 3 == 0) sup_ignore();
            leave($urandom & 32'hFFFF_FFFC, $urandom, $urandom, $urandom, it[0]);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule